// File: doc/BRIEF.md
# Radix-4 In-Place FFT Engine

This block computes a 16-point complex discrete Fourier transform on signed fixed-point samples held in a single internal sample store. The host fills the store through a write port, one complex sample per clock, in any order, with each sample at its natural time index. A one-cycle start pulse then launches the transform. The engine reads the store, runs two radix-4 decimation-in-frequency stages and writes each result back to the addresses it came from. No second buffer is used.

A single butterfly unit serves both stages. It takes one new butterfly every four clocks, so the run lasts exactly 36 clocks: eight read windows, plus one trailing write window. While the run is in progress, busy is high. At the end, done rises and the host reads the sixteen bins in natural frequency order. The read port swaps the two base-4 address digits, so the host never sees the digit-reversed layout left in the store.

Each stage divides its result by four, so the output is the DFT scaled by 1/16. Inputs should stay within about half of full scale so that the twiddle rotation does not overflow.

Top module: `fft16_core`

## Requirements
- R1: A cycle with wr_en high while the engine is idle stores {wr_re, wr_im} at time index wr_addr. The load order is free, and each address keeps its last write.
- R2: A start pulse while idle begins a transform: busy is high and done is low from the next clock edge on. After reset, busy and done are both low.
- R3: busy stays high for exactly 36 clock cycles after the accepted start. On the edge that clears busy, done is set.
- R4: done stays high until the next accepted start and is never high together with busy.
- R5: Once done, reading rd_addr = m returns bin m of X[m] = sum over n of x[n]·e^(-j2πnm/16), divided by 16. Each of the real and imaginary parts is within 4 LSB, and the read is combinational with no latency.
- R6: A constant input c at all 16 addresses yields exactly c at bin 0 and exactly 0 at bins 1 to 15.
- R7: An input of value a at address 0, with zero elsewhere, yields exactly (a >>> 4), an arithmetic shift right by 4, in both parts of every bin.
- R8: Host writes while busy have no effect on the stored data or on the results.
- R9: While busy, rd_re and rd_im read zero whatever rd_addr is.
- R10: A start pulse while busy is ignored: the run still ends 36 cycles after the start that was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host sample write strobe |
| wr_addr | input | 4 | Time index of the written sample |
| wr_re | input | 16 | Real part of written sample, two's complement |
| wr_im | input | 16 | Imaginary part of written sample, two's complement |
| start | input | 1 | Start pulse for a transform |
| rd_addr | input | 4 | Frequency bin to read, natural order |
| rd_re | output | 16 | Real part of the addressed bin |
| rd_im | output | 16 | Imaginary part of the addressed bin |
| busy | output | 1 | Transform in progress |
| done | output | 1 | Results valid in the store |

## Verification
The hardest situation to reach from the ports is the hand-over at the stage boundary. There, the last first-stage butterfly is still writing addresses 3, 7, 11 and 15 while the first second-stage butterfly is already reading addresses 0 to 3. A wrong write order or a stale read shows up only with data where every one of these addresses carries a distinct, non-trivial value. The bench therefore uses dense pseudo-random complex data and a complex tone off the axis, both checked against a DFT computed in real arithmetic, alongside exact impulse and constant patterns. Separately, it runs a transform while flooding the write port, the start input and the read port, then checks the run length and the final bins.

// File: rtl/fft16_pkg.sv
`timescale 1ns/1ps
package fft16_pkg;
    localparam int DATA_W      = 16;
    localparam int TWID_W      = 16;
    localparam int POINTS      = 16;
    localparam int RADIX       = 4;
    localparam int STAGES      = 2;
    localparam int ADDR_W      = $clog2(POINTS);
    localparam int DIGIT_W     = $clog2(RADIX);
    localparam int BFLY_CYC    = RADIX;
    localparam int BFLY_TOTAL  = STAGES * (POINTS / RADIX);
    localparam int RUN_CYC     = (BFLY_TOTAL + 1) * BFLY_CYC;
    localparam int CNT_W       = $clog2(RUN_CYC);

    typedef struct packed {
        logic signed [DATA_W-1:0] re;
        logic signed [DATA_W-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic signed [TWID_W-1:0] re;
        logic signed [TWID_W-1:0] im;
    } twid_t;
endpackage

// File: rtl/fft16_ram.sv
`timescale 1ns/1ps
module fft16_ram
    import fft16_pkg::*;
#(
    parameter int DEPTH = POINTS,
    parameter int AW    = ADDR_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  cplx_t         wdata,
    input  logic [AW-1:0] raddr,
    output cplx_t         rdata
);
    cplx_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/fft16_twiddle_rom.sv
`timescale 1ns/1ps
module fft16_twiddle_rom
    import fft16_pkg::*;
(
    input  logic [ADDR_W-1:0] idx,
    output twid_t             w
);
    // Entry m holds exp(-j*2*pi*m/16) in Q1.15; indices above 9 never occur.
    always_comb begin
        case (idx)
            4'd1:    w = '{re:  16'sd30274, im: -16'sd12540};
            4'd2:    w = '{re:  16'sd23170, im: -16'sd23170};
            4'd3:    w = '{re:  16'sd12540, im: -16'sd30274};
            4'd4:    w = '{re:  16'sd0,     im: -16'sd32767};
            4'd5:    w = '{re: -16'sd12540, im: -16'sd30274};
            4'd6:    w = '{re: -16'sd23170, im: -16'sd23170};
            4'd7:    w = '{re: -16'sd30274, im: -16'sd12540};
            4'd8:    w = '{re: -16'sd32768, im:  16'sd0};
            4'd9:    w = '{re: -16'sd30274, im:  16'sd12540};
            default: w = '{re:  16'sd32767, im:  16'sd0};
        endcase
    end
endmodule

// File: rtl/fft16_bfly.sv
`timescale 1ns/1ps
module fft16_bfly
    import fft16_pkg::*;
(
    input  cplx_t [RADIX-1:0]   x,
    input  logic [DIGIT_W-1:0]  grp,
    input  logic                last_stage,
    output cplx_t [RADIX-1:0]   y
);
    localparam int SW = DATA_W + 3;
    localparam int PW = DATA_W + TWID_W + 1;
    localparam logic signed [PW-1:0] RND = PW'(1) <<< (TWID_W - 2);

    logic signed [SW-1:0] xr [RADIX];
    logic signed [SW-1:0] xi [RADIX];
    logic signed [SW-1:0] sr [RADIX];
    logic signed [SW-1:0] si [RADIX];
    cplx_t [RADIX-1:0]    sc;
    cplx_t                tw_out [1:RADIX-1];
    logic                 bypass;

    // 4-point DFT with W4 = -j, then divide by four.
    always_comb begin
        for (int j = 0; j < RADIX; j++) begin
            xr[j] = SW'(x[j].re);
            xi[j] = SW'(x[j].im);
        end
        sr[0] = xr[0] + xr[1] + xr[2] + xr[3];
        si[0] = xi[0] + xi[1] + xi[2] + xi[3];
        sr[1] = xr[0] + xi[1] - xr[2] - xi[3];
        si[1] = xi[0] - xr[1] - xi[2] + xr[3];
        sr[2] = xr[0] - xr[1] + xr[2] - xr[3];
        si[2] = xi[0] - xi[1] + xi[2] - xi[3];
        sr[3] = xr[0] - xi[1] - xr[2] + xi[3];
        si[3] = xi[0] + xr[1] - xi[2] - xr[3];
        for (int k = 0; k < RADIX; k++) begin
            sc[k].re = DATA_W'(sr[k] >>> DIGIT_W);
            sc[k].im = DATA_W'(si[k] >>> DIGIT_W);
        end
    end

    generate
        for (genvar k = 1; k < RADIX; k++) begin : g_rot
            logic [ADDR_W-1:0]        tw_idx;
            twid_t                    w;
            logic signed [DATA_W-1:0] ar;
            logic signed [DATA_W-1:0] ai;
            logic signed [PW-1:0]     pr;
            logic signed [PW-1:0]     pi;

            assign tw_idx = ADDR_W'(grp) * ADDR_W'(k);

            fft16_twiddle_rom rom_i (
                .idx (tw_idx),
                .w   (w)
            );

            assign ar = sc[k].re;
            assign ai = sc[k].im;
            assign pr = PW'(ar) * PW'(w.re) - PW'(ai) * PW'(w.im) + RND;
            assign pi = PW'(ar) * PW'(w.im) + PW'(ai) * PW'(w.re) + RND;
            assign tw_out[k].re = DATA_W'(pr >>> (TWID_W - 1));
            assign tw_out[k].im = DATA_W'(pi >>> (TWID_W - 1));
        end
    endgenerate

    // Unity twiddle in the last stage and for group 0: pass through exactly.
    assign bypass = last_stage || (grp == '0);

    always_comb begin
        y[0] = sc[0];
        for (int k = 1; k < RADIX; k++) begin
            y[k] = bypass ? sc[k] : tw_out[k];
        end
    end
endmodule

// File: rtl/fft16_core.sv
`timescale 1ns/1ps
module fft16_core
    import fft16_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic signed [DATA_W-1:0] wr_re,
    input  logic signed [DATA_W-1:0] wr_im,
    input  logic                     start,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic signed [DATA_W-1:0] rd_re,
    output logic signed [DATA_W-1:0] rd_im,
    output logic                     busy,
    output logic                     done
);
    localparam int B_W    = $clog2(BFLY_TOTAL);
    localparam int J_W    = DIGIT_W;
    localparam int RD_CYC = BFLY_TOTAL * BFLY_CYC;

    typedef struct packed {
        logic                busy;
        logic                done;
        logic [CNT_W-1:0]    cnt;
        cplx_t [RADIX-2:0]   xcap;
        cplx_t [RADIX-1:0]   ybuf;
    } eng_t;

    eng_t                st_d, st_q;
    logic [J_W-1:0]      ph;
    logic [B_W-1:0]      rb, wb;
    logic                rd_phase, wr_phase, last_cyc;
    logic [ADDR_W-1:0]   eng_raddr, eng_waddr, host_raddr;
    logic [ADDR_W-1:0]   ram_raddr, ram_waddr;
    logic                ram_we;
    cplx_t               ram_rdata, ram_wdata;
    cplx_t [RADIX-1:0]   bf_in, bf_out;

    // Stage 0 holds butterfly g at {j,g}; stage 1 holds it at {g,j}.
    function automatic logic [ADDR_W-1:0] addr_of(input logic [B_W-1:0] b,
                                                  input logic [J_W-1:0] j);
        if (b[B_W-1]) begin
            return {b[J_W-1:0], j};
        end
        return {j, b[J_W-1:0]};
    endfunction

    always_comb begin
        ph         = st_q.cnt[J_W-1:0];
        rb         = st_q.cnt[J_W +: B_W];
        wb         = rb - B_W'(1);
        rd_phase   = st_q.cnt < CNT_W'(RD_CYC);
        wr_phase   = st_q.cnt >= CNT_W'(BFLY_CYC);
        last_cyc   = st_q.cnt == CNT_W'(RUN_CYC - 1);
        eng_raddr  = addr_of(rb, ph);
        eng_waddr  = addr_of(wb, ph);
        host_raddr = {rd_addr[J_W-1:0], rd_addr[ADDR_W-1:J_W]};
    end

    always_comb begin
        if (st_q.busy) begin
            ram_we    = wr_phase;
            ram_waddr = eng_waddr;
            ram_wdata = st_q.ybuf[ph];
            ram_raddr = eng_raddr;
        end else begin
            ram_we    = wr_en;
            ram_waddr = wr_addr;
            ram_wdata = '{re: wr_re, im: wr_im};
            ram_raddr = host_raddr;
        end
    end

    fft16_ram ram_i (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    always_comb begin
        for (int j = 0; j < RADIX - 1; j++) begin
            bf_in[j] = st_q.xcap[j];
        end
        bf_in[RADIX-1] = ram_rdata;
    end

    fft16_bfly bfly_i (
        .x          (bf_in),
        .grp        (rb[J_W-1:0]),
        .last_stage (rb[B_W-1]),
        .y          (bf_out)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.done = 1'b0;
                st_d.cnt  = '0;
            end
        end else begin
            if (rd_phase) begin
                if (ph != J_W'(RADIX - 1)) begin
                    st_d.xcap[ph] = ram_rdata;
                end else begin
                    st_d.ybuf = bf_out;
                end
            end
            if (last_cyc) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = st_q.busy;
    assign done  = st_q.done;
    assign rd_re = st_q.busy ? '0 : ram_rdata.re;
    assign rd_im = st_q.busy ? '0 : ram_rdata.im;
endmodule

// File: rtl/fft16_core_chk.sv
`timescale 1ns/1ps
module fft16_core_chk
    import fft16_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     busy,
    input logic                     done,
    input logic signed [DATA_W-1:0] rd_re,
    input logic signed [DATA_W-1:0] rd_im
);
    localparam int RC_W = CNT_W + 1;
    logic [RC_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + RC_W'(1);
        end else begin
            run_cnt <= '0;
        end
    end

    p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done));

    p_idle_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    p_busy_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == RC_W'(RUN_CYC)));

    p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < RC_W'(RUN_CYC)));

    p_done_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_done_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_re == '0 && rd_im == '0));

    p_restart_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && run_cnt < RC_W'(RUN_CYC - 1)) |=> busy);
endmodule

bind fft16_core fft16_core_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .rd_re (rd_re),
    .rd_im (rd_im)
);

// File: tb/fft16_core_tb_top.sv
`timescale 1ns/1ps
module fft16_core_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [3:0]         wr_addr = '0;
    logic signed [15:0] wr_re = '0;
    logic signed [15:0] wr_im = '0;
    logic               start = 1'b0;
    logic [3:0]         rd_addr = '0;
    logic signed [15:0] rd_re, rd_im;
    logic               busy, done;

    int checks = 0;
    int errors = 0;
    logic rd_req = 1'b0;

    int    q_addr[$];
    int    q_re[$];
    int    q_im[$];
    int    q_tol[$];
    string q_tag[$];

    int xs_re[16];
    int xs_im[16];
    int g_re[16];
    int g_im[16];

    always #2.5 clk = ~clk;

    fft16_core dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_re(wr_re), .wr_im(wr_im), .start(start), .rd_addr(rd_addr),
        .rd_re(rd_re), .rd_im(rd_im), .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Monitor: pops one expected bin per requested read.
    always @(negedge clk) begin
        if (rd_req && q_addr.size() > 0) begin
            int a, er, ei, tol;
            string tg;
            a = q_addr.pop_front(); er = q_re.pop_front(); ei = q_im.pop_front();
            tol = q_tol.pop_front(); tg = q_tag.pop_front();
            checks++;
            if (iabs(int'(rd_re) - er) > tol || iabs(int'(rd_im) - ei) > tol) begin
                errors++;
                $display("FAIL %s bin %0d: actual (%0d,%0d) expected (%0d,%0d) tol %0d",
                         tg, a, rd_re, rd_im, er, ei, tol);
            end
        end
    end

    // Driver: queue the expectation, then present the address.
    task automatic read_bins(input int tol, input string tag);
        for (int m = 0; m < 16; m++) begin
            @(posedge clk); #1;
            q_addr.push_back(m); q_re.push_back(g_re[m]); q_im.push_back(g_im[m]);
            q_tol.push_back(tol); q_tag.push_back(tag);
            rd_addr = 4'(m);
            rd_req  = 1'b1;
        end
        @(posedge clk); #1;
        rd_req = 1'b0;
    endtask

    task automatic load(input bit reverse);
        for (int i = 0; i < 16; i++) begin
            int n;
            n = reverse ? 15 - i : i;
            @(posedge clk); #1;
            wr_en = 1'b1; wr_addr = 4'(n);
            wr_re = 16'(xs_re[n]); wr_im = 16'(xs_im[n]);
        end
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic golden();
        for (int m = 0; m < 16; m++) begin
            real sr, si, th;
            sr = 0.0; si = 0.0;
            for (int n = 0; n < 16; n++) begin
                th = 2.0 * 3.14159265358979 * real'(n * m) / 16.0;
                sr = sr + real'(xs_re[n]) * $cos(th) + real'(xs_im[n]) * $sin(th);
                si = si + real'(xs_im[n]) * $cos(th) - real'(xs_re[n]) * $sin(th);
            end
            g_re[m] = int'($floor(sr / 16.0 + 0.5));
            g_im[m] = int'($floor(si / 16.0 + 0.5));
        end
    endtask

    task automatic run_xform(input bit disturb);
        int cyc;
        cyc = 0;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        forever begin
            @(negedge clk);
            if (!busy) break;
            cyc++;
            if (cyc == 1) begin
                chk("R2", "busy after start", int'(busy), 1);
                chk("R2", "done cleared by start", int'(done), 0);
            end
            if (disturb) begin
                if (cyc % 6 == 2) begin
                    chk("R9", "rd_re while busy", int'(rd_re), 0);
                    chk("R9", "rd_im while busy", int'(rd_im), 0);
                end
                if (cyc < 30) begin
                    wr_en = 1'b1; wr_addr = 4'(cyc);
                    wr_re = 16'sh7f00; wr_im = -16'sh1234;
                    start = (cyc % 5 == 0);
                    rd_addr = 4'(cyc * 3);
                end else begin
                    wr_en = 1'b0; start = 1'b0;
                end
            end
            if (cyc > 100) break;
        end
        wr_en = 1'b0; start = 1'b0;
        chk(disturb ? "R10" : "R3", "busy cycles", cyc, 36);
        chk("R3", "done at end of run", int'(done), 1);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual hung run expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R2", "busy after reset", int'(busy), 0);
        chk("R4", "done after reset", int'(done), 0);

        // R7: complex impulse at index 0 gives a >>> 4 in every bin.
        for (int n = 0; n < 16; n++) begin xs_re[n] = 0; xs_im[n] = 0; end
        xs_re[0] = 1000; xs_im[0] = -520;
        load(1'b0);
        run_xform(1'b0);
        for (int m = 0; m < 16; m++) begin g_re[m] = 1000 >>> 4; g_im[m] = -520 >>> 4; end
        read_bins(0, "R7");
        chk("R4", "done holds after reads", int'(done), 1);

        // R6: constant input lands only in bin 0, exactly.
        for (int n = 0; n < 16; n++) begin xs_re[n] = 3000; xs_im[n] = 1200; end
        load(1'b0);
        run_xform(1'b0);
        for (int m = 0; m < 16; m++) begin g_re[m] = 0; g_im[m] = 0; end
        g_re[0] = 3000; g_im[0] = 1200;
        read_bins(0, "R6");

        // R5: complex tone at bin 3.
        for (int n = 0; n < 16; n++) begin
            real th;
            th = 2.0 * 3.14159265358979 * real'(3 * n) / 16.0;
            xs_re[n] = int'($floor(5000.0 * $cos(th) + 0.5));
            xs_im[n] = int'($floor(5000.0 * $sin(th) + 0.5));
        end
        load(1'b0);
        run_xform(1'b0);
        golden();
        read_bins(4, "R5");

        // R1 and R5: dense pseudo-random data loaded in reverse order.
        seed = 32'd12345;
        for (int n = 0; n < 16; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            xs_re[n] = int'((seed >> 16) % 12001) - 6000;
            seed = seed * 32'd1103515245 + 32'd12345;
            xs_im[n] = int'((seed >> 16) % 12001) - 6000;
        end
        load(1'b1);
        run_xform(1'b0);
        golden();
        read_bins(4, "R1");

        // R8, R9, R10: new data, then flood writes, starts and reads while busy.
        for (int n = 0; n < 16; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            xs_re[n] = int'((seed >> 16) % 8001) - 4000;
            seed = seed * 32'd1103515245 + 32'd12345;
            xs_im[n] = int'((seed >> 16) % 8001) - 4000;
        end
        load(1'b0);
        run_xform(1'b1);
        golden();
        read_bins(4, "R8");

        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule